// File: doc/BRIEF.md
# Data-Strobe Link Character Receiver

This block receives a serial link that carries data on one wire and a strobe on a second wire. It recovers each bit by sampling both wires with a local sampling clock. It frames the bits into characters and checks their parity. It reports what it has received. A bit arrives whenever the exclusive-OR of data and strobe changes, and the bit's value is the data wire at that moment. After reset the framer searches the bit stream one bit at a time for the first NULL. From then on it frames characters back to back. A flag bit of 0 starts a 10-bit data character and a flag bit of 1 starts a 4-bit control character.

Data bytes and end-of-packet markers are written out as 9-bit words for a receive FIFO. The FIFO runs in the sampling domain. Flow-control tokens and time codes are raised as single pulses in the system clock domain after a toggle handshake. A parity fault, or an escape followed by anything other than a flow-control token or a data byte, puts the block into a sticky error state. That state stops all further output until reset.

Top module: `dsrx_top`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `fifo_wr_o`, `null_o`, `err_o`, `fct_o` and `tick_o` are 0 and `time_o` is 0.
- R2: A bit is taken each time `din_i ^ sin_i` changes, and its value is `din_i`. Within a character, bits arrive as parity, flag, then the payload least significant bit first.
- R3: Until the first NULL, nothing is written and no event is raised, whatever the bit alignment of the preceding traffic. The first NULL is found at any bit offset and gives one `null_o` pulse.
- R4: A data character (flag 0, 8 payload bits) is written as `fifo_data_o = {1'b0, byte}` with one `fifo_wr_o` pulse.
- R5: Control codes use payload bit order (first, second): FCT = (0,0), EOP = (0,1), EEP = (1,0), ESC = (1,1). EOP is written as 9'h100 and EEP as 9'h101.
- R6: Each FCT that is not preceded by ESC gives exactly one `fct_o` pulse in the `clk_i` domain and no FIFO write.
- R7: ESC followed by a data character gives one `tick_o` pulse in the `clk_i` domain, with `time_o` equal to the byte. `time_o` changes only together with `tick_o`, and nothing is written.
- R8: ESC followed by FCT after link start is a NULL. It gives one `null_o` pulse, with no write and no `fct_o`.
- R9: Parity is odd over the previous character's payload bits and the current parity and flag bits. A mismatch sets `err_o`, which stays set until reset and blocks all further writes.
- R10: ESC followed by ESC, EOP or EEP sets `err_o` with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk_i | input | 1 | Sampling clock for the line, the framer and the FIFO write side |
| clk_i | input | 1 | System clock receiving FCT and time-code events |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| din_i | input | 1 | Serial data wire |
| sin_i | input | 1 | Serial strobe wire |
| fifo_wr_o | output | 1 | FIFO write strobe (sampling domain) |
| fifo_data_o | output | 9 | Bit 8 set marks a packet end, otherwise bits 7:0 are a data byte |
| null_o | output | 1 | Pulse per NULL received (sampling domain) |
| err_o | output | 1 | Sticky parity or escape-sequence error |
| fct_o | output | 1 | Pulse per flow-control token (system domain) |
| tick_o | output | 1 | Pulse per time code (system domain) |
| time_o | output | 8 | Last received time-code byte (system domain) |

## Verification
Error detection and the FIFO write fall on the same edge: the final bit of a data character with bad parity is the bit that completes a write and also reveals the fault. The bench provokes this by inverting the parity bit of a data character. It then requires `err_o` to be set and no word to have reached the FIFO. A well-formed character sent afterwards must not be written either. The escape-misuse cases are judged the same way.

// File: rtl/dsrx_pkg.sv
package dsrx_pkg;
  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 2;
  localparam int DCHAR_W  = DATA_W + 2;
  localparam int CCHAR_W  = CTRL_W + 2;
  localparam int CNT_W    = $clog2(DCHAR_W);
  localparam int WORD_W   = DATA_W + 1;
  localparam int HUNT_W   = 2 * CCHAR_W - 1;

  // code = {first payload bit, second payload bit}
  localparam logic [CTRL_W-1:0] C_FCT = 2'b00;
  localparam logic [CTRL_W-1:0] C_EOP = 2'b01;
  localparam logic [CTRL_W-1:0] C_EEP = 2'b10;
  localparam logic [CTRL_W-1:0] C_ESC = 2'b11;

  // arrival window, newest bit at index 0; leading ESC parity bit excluded
  localparam logic [HUNT_W-1:0] NULL_PAT =
    {1'b1, C_ESC[1], C_ESC[0], ^C_ESC, 1'b1, C_FCT[1], C_FCT[0]};

  localparam logic [WORD_W-1:0] W_EOP = {1'b1, {(DATA_W-1){1'b0}}, 1'b0};
  localparam logic [WORD_W-1:0] W_EEP = {1'b1, {(DATA_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_RUN  = 2'd1,
    ST_ERR  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/dsrx_front.sv
module dsrx_front #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic sin_i,
  output logic bit_vld_o,
  output logic bit_val_o
);
  logic [STAGES-1:0] d_sr, s_sr;
  logic              x_prev;
  logic              x_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_sr <= '0;
      s_sr <= '0;
    end else begin
      d_sr <= {d_sr[STAGES-2:0], din_i};
      s_sr <= {s_sr[STAGES-2:0], sin_i};
    end
  end

  assign x_now = d_sr[STAGES-1] ^ s_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_prev <= 1'b0;
    else         x_prev <= x_now;
  end

  assign bit_vld_o = x_now ^ x_prev;
  assign bit_val_o = d_sr[STAGES-1];
endmodule

// File: rtl/dsrx_framer.sv
module dsrx_framer
  import dsrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              null_o,
  output logic              fct_o,
  output logic              tc_o,
  output logic [DATA_W-1:0] tc_data_o,
  output logic              err_o,
  output logic              hunting_o
);
  rx_state_e           state_q;
  logic [HUNT_W-2:0]   hist_q;
  logic [DCHAR_W-1:0]  cur_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                prev_par_q;
  logic                esc_q;

  logic [HUNT_W-1:0]   win;
  logic [DCHAR_W-1:0]  chr;
  logic                flag, done, par_ok;
  logic [CTRL_W-1:0]   code;
  logic [DATA_W-1:0]   byte_v;

  always_comb begin
    win = {hist_q, bit_val_i};
    chr = cur_q;
    chr[cnt_q] = bit_val_i;
    flag   = chr[1];
    code   = {chr[2], chr[3]};
    byte_v = chr[DCHAR_W-1:2];
    done   = bit_vld_i && (state_q == ST_RUN) &&
             ((flag && cnt_q == CNT_W'(CCHAR_W-1)) ||
              (!flag && cnt_q == CNT_W'(DCHAR_W-1)));
    par_ok = chr[0] ^ chr[1] ^ prev_par_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      hist_q     <= '0;
      cur_q      <= '0;
      cnt_q      <= '0;
      prev_par_q <= 1'b0;
      esc_q      <= 1'b0;
      wr_o       <= 1'b0;
      wdata_o    <= '0;
      null_o     <= 1'b0;
      fct_o      <= 1'b0;
      tc_o       <= 1'b0;
      tc_data_o  <= '0;
    end else begin
      wr_o   <= 1'b0;
      null_o <= 1'b0;
      fct_o  <= 1'b0;
      tc_o   <= 1'b0;
      unique case (state_q)
        ST_HUNT: if (bit_vld_i) begin
          hist_q <= win[HUNT_W-2:0];
          if (win[HUNT_W-1:0] == NULL_PAT) begin
            state_q    <= ST_RUN;
            null_o     <= 1'b1;
            cnt_q      <= '0;
            prev_par_q <= ^C_FCT;
            esc_q      <= 1'b0;
          end
        end
        ST_RUN: if (bit_vld_i) begin
          if (!done) begin
            cur_q <= chr;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q      <= '0;
            prev_par_q <= flag ? ^code : ^byte_v;
            if (!par_ok) begin
              state_q <= ST_ERR;
            end else if (flag) begin
              if (esc_q) begin
                esc_q <= 1'b0;
                if (code == C_FCT) null_o  <= 1'b1;
                else               state_q <= ST_ERR;
              end else begin
                unique case (code)
                  C_FCT: fct_o <= 1'b1;
                  C_EOP: begin wr_o <= 1'b1; wdata_o <= W_EOP; end
                  C_EEP: begin wr_o <= 1'b1; wdata_o <= W_EEP; end
                  default: esc_q <= 1'b1;
                endcase
              end
            end else if (esc_q) begin
              esc_q     <= 1'b0;
              tc_o      <= 1'b1;
              tc_data_o <= byte_v;
            end else begin
              wr_o    <= 1'b1;
              wdata_o <= {1'b0, byte_v};
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign err_o     = (state_q == ST_ERR);
  assign hunting_o = (state_q == ST_HUNT);
endmodule

// File: rtl/dsrx_evsync.sv
module dsrx_evsync #(
  parameter int STAGES = 2
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  logic            tgl_q;
  logic [STAGES:0] sync_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)      tgl_q <= 1'b0;
    else if (pulse_i) tgl_q <= ~tgl_q;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], tgl_q};
  end

  assign pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/dsrx_top.sv
module dsrx_top
  import dsrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              smp_clk_i,
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              sin_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic              null_o,
  output logic              err_o,
  output logic              fct_o,
  output logic              tick_o,
  output logic [DATA_W-1:0] time_o
);
  logic              bit_vld, bit_val;
  logic              fct_smp, tc_smp, fct_sys, tc_sys;
  logic [DATA_W-1:0] tc_hold;
  logic              hunting;

  dsrx_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i     (smp_clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din_i),
    .sin_i     (sin_i),
    .bit_vld_o (bit_vld),
    .bit_val_o (bit_val)
  );

  dsrx_framer u_framer (
    .clk_i     (smp_clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld),
    .bit_val_i (bit_val),
    .wr_o      (fifo_wr_o),
    .wdata_o   (fifo_data_o),
    .null_o    (null_o),
    .fct_o     (fct_smp),
    .tc_o      (tc_smp),
    .tc_data_o (tc_hold),
    .err_o     (err_o),
    .hunting_o (hunting)
  );

  dsrx_evsync #(.STAGES(SYNC_STAGES)) u_fct_sync (
    .src_clk_i (smp_clk_i),
    .dst_clk_i (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (fct_smp),
    .pulse_o   (fct_sys)
  );

  dsrx_evsync #(.STAGES(SYNC_STAGES)) u_tc_sync (
    .src_clk_i (smp_clk_i),
    .dst_clk_i (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (tc_smp),
    .pulse_o   (tc_sys)
  );

  // tc_hold is stable for many sample cycles around each toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fct_o  <= 1'b0;
      tick_o <= 1'b0;
      time_o <= '0;
    end else begin
      fct_o  <= fct_sys;
      tick_o <= tc_sys;
      if (tc_sys) time_o <= tc_hold;
    end
  end
endmodule

// File: rtl/dsrx_chk.sv
module dsrx_chk
  import dsrx_pkg::*;
(
  input logic              smp_clk_i,
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_wr_o,
  input logic [WORD_W-1:0] fifo_data_o,
  input logic              null_o,
  input logic              err_o,
  input logic              fct_o,
  input logic              tick_o,
  input logic [DATA_W-1:0] time_o,
  input logic              hunting
);
  assert_no_write_hunting_R3: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    hunting |-> !fifo_wr_o);

  assert_marker_code_R5: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    (fifo_wr_o && fifo_data_o[WORD_W-1]) |-> (fifo_data_o[DATA_W-1:1] == '0));

  assert_null_no_write_R8: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    null_o |-> !fifo_wr_o);

  assert_err_sticky_R9: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_no_write_after_err_R9: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    err_o |-> !fifo_wr_o);

  assert_fct_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fct_o |=> !fct_o);

  assert_time_with_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(time_o) |-> tick_o);
endmodule

bind dsrx_top dsrx_chk u_chk (
  .smp_clk_i   (smp_clk_i),
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_data_o (fifo_data_o),
  .null_o      (null_o),
  .err_o       (err_o),
  .fct_o       (fct_o),
  .tick_o      (tick_o),
  .time_o      (time_o),
  .hunting     (hunting)
);

// File: tb/sim_dsrx_top.sv
module sim_dsrx_top;
  logic       smp_clk = 1'b0;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d = 1'b0, s = 1'b0;
  logic       fifo_wr, null_p, err, fct, tick;
  logic [8:0] fifo_data;
  logic [7:0] time_v;

  always #4 smp_clk = ~smp_clk;
  always #5 clk = ~clk;

  dsrx_top u0 (
    .smp_clk_i(smp_clk), .clk_i(clk), .rst_ni(rst_n),
    .din_i(d), .sin_i(s),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
    .null_o(null_p), .err_o(err),
    .fct_o(fct), .tick_o(tick), .time_o(time_v)
  );

  int checks = 0, errors = 0;
  int wcnt, ncnt, fcnt, tcnt;
  logic [8:0] wlog [0:15];
  logic [7:0] tlast;
  logic ppar;

  localparam logic [1:0] FCT = 2'b00, EOP = 2'b01, EEP = 2'b10, ESC = 2'b11;

  always @(negedge smp_clk) if (rst_n) begin
    if (fifo_wr) begin
      if (wcnt < 16) wlog[wcnt] = fifo_data;
      wcnt++;
    end
    if (null_p) ncnt++;
  end

  always @(negedge clk) if (rst_n) begin
    if (fct) fcnt++;
    if (tick) begin tcnt++; tlast = time_v; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; d = 1'b0; s = 1'b0; ppar = 1'b0;
    wcnt = 0; ncnt = 0; fcnt = 0; tcnt = 0; tlast = 8'h00;
    repeat (3) @(negedge smp_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge smp_clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge smp_clk);
    if (b != d) d = b;
    else        s = ~s;
    repeat (3) @(negedge smp_clk);
  endtask

  task automatic send_char(input logic flag, input logic [7:0] pl, input bit bad);
    int n;
    logic p;
    n = flag ? 2 : 8;
    p = ~(flag ^ ppar) ^ bad;
    send_bit(p);
    send_bit(flag);
    for (int i = 0; i < n; i++) send_bit(pl[i]);
    ppar = flag ? (pl[0] ^ pl[1]) : ^pl;
  endtask

  task automatic send_ctrl(input logic [1:0] c, input bit bad);
    send_char(1'b1, {6'b0, c[0], c[1]}, bad);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic link_start();
    do_reset();
    send_bit(1'b0); send_bit(1'b1);
    send_ctrl(ESC, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!fifo_wr && !null_p && !err && !fct && !tick && time_v == 0, "R1 in reset",
        {fifo_wr, null_p, err, fct, tick, time_v}, 0);
    do_reset();
    chk(!fifo_wr && !null_p && !err && !fct && !tick && time_v == 0, "R1 after release",
        {fifo_wr, null_p, err, fct, tick, time_v}, 0);
  endtask

  task automatic t_hunt();
    do_reset();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_char(1'b0, 8'hA5, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
    chk(wcnt == 0 && fcnt == 0 && ncnt == 0, "R3 silent before NULL", wcnt + fcnt + ncnt, 0);
    send_ctrl(ESC, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
    chk(ncnt == 1, "R3 NULL found at odd offset", ncnt, 1);
    send_char(1'b0, 8'h3C, 1'b0);
    settle();
    chk(wcnt == 1 && wlog[0] == 9'h03C, "R3 framing after hunt", wlog[0], 9'h03C);
    // second alignment: no garbage at all
    do_reset();
    send_ctrl(ESC, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
    chk(ncnt == 1 && !err, "R3 NULL at offset zero", ncnt, 1);
  endtask

  task automatic t_data();
    logic [7:0] v [0:3];
    v[0] = 8'h00; v[1] = 8'hFF; v[2] = 8'h81; v[3] = 8'h5A;
    link_start();
    for (int i = 0; i < 4; i++) send_char(1'b0, v[i], 1'b0);
    settle();
    chk(wcnt == 4, "R4 write count", wcnt, 4);
    for (int i = 0; i < 4; i++)
      chk(wlog[i] == {1'b0, v[i]}, "R2 R4 data byte", wlog[i], {1'b0, v[i]});
  endtask

  task automatic t_eop();
    link_start();
    send_char(1'b0, 8'h11, 1'b0);
    send_ctrl(EOP, 1'b0);
    send_ctrl(EEP, 1'b0);
    settle();
    chk(wcnt == 3, "R5 write count", wcnt, 3);
    chk(wlog[1] == 9'h100, "R5 EOP word", wlog[1], 9'h100);
    chk(wlog[2] == 9'h101, "R5 EEP word", wlog[2], 9'h101);
  endtask

  task automatic t_fct();
    link_start();
    for (int i = 0; i < 3; i++) begin
      send_ctrl(FCT, 1'b0);
      settle();
    end
    chk(fcnt == 3, "R6 FCT pulses", fcnt, 3);
    chk(wcnt == 0 && tcnt == 0, "R6 no write", wcnt, 0);
  endtask

  task automatic t_time();
    link_start();
    send_ctrl(ESC, 1'b0);
    send_char(1'b0, 8'h2B, 1'b0);
    settle();
    chk(tcnt == 1 && tlast == 8'h2B && time_v == 8'h2B, "R7 time code", time_v, 8'h2B);
    send_char(1'b0, 8'h44, 1'b0);
    settle();
    chk(time_v == 8'h2B, "R7 time_o held", time_v, 8'h2B);
    send_ctrl(ESC, 1'b0);
    send_char(1'b0, 8'h3F, 1'b0);
    settle();
    chk(tcnt == 2 && time_v == 8'h3F, "R7 second time code", time_v, 8'h3F);
    chk(wcnt == 1 && wlog[0] == 9'h044, "R7 only plain byte written", wcnt, 1);
  endtask

  task automatic t_null();
    link_start();
    send_ctrl(ESC, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
    chk(ncnt == 2, "R8 NULL pulse", ncnt, 2);
    chk(wcnt == 0 && fcnt == 0 && !err, "R8 no side effect", wcnt + fcnt + err, 0);
  endtask

  task automatic t_perr();
    link_start();
    send_char(1'b0, 8'h77, 1'b1);
    settle();
    chk(err, "R9 parity error flagged", err, 1);
    chk(wcnt == 0, "R9 bad char not written", wcnt, 0);
    send_char(1'b0, 8'h12, 1'b0);
    send_ctrl(FCT, 1'b0);
    settle();
    chk(err && wcnt == 0 && fcnt == 0, "R9 sticky, writes blocked", wcnt + fcnt, 0);
    link_start();
    send_ctrl(FCT, 1'b1);
    settle();
    chk(err && fcnt == 0, "R9 control parity error", fcnt, 0);
  endtask

  task automatic t_escerr();
    link_start();
    send_ctrl(ESC, 1'b0);
    send_ctrl(EOP, 1'b0);
    settle();
    chk(err && wcnt == 0, "R10 ESC EOP", {err, wcnt[7:0]}, 9'h100);
    link_start();
    send_ctrl(ESC, 1'b0);
    send_ctrl(ESC, 1'b0);
    settle();
    chk(err, "R10 ESC ESC", err, 1);
    link_start();
    send_ctrl(ESC, 1'b0);
    send_ctrl(EEP, 1'b0);
    settle();
    chk(err && wcnt == 0, "R10 ESC EEP", {err, wcnt[7:0]}, 9'h100);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hunt();
    t_data();
    t_eop();
    t_fct();
    t_time();
    t_null();
    t_perr();
    t_escerr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule